// File: doc/BRIEF.md
# Search Result Latency Pipeline

This block sits between a search core and the external result memory of a lookup engine. The search core hands it one result per cycle: a command strobe, a hit flag, a write-back flag and a 24-bit winning address. The block holds each result for a fixed number of cycles and then drives the memory address with active-low chip-enable, address-latch-enable and write-enable strobes. The number of cycles depends on a table-size code. Larger tables need more cycles, because the cascade has more devices to settle.

A valid/found status pair follows the address side. A 3-bit hold code moves it between zero and seven cycles later. When a search misses, the miss cycle is still driven, but only by a device whose two configuration bits mark it as both last in its bank and last in the cascade. Every other device stays silent on a miss. The pipeline takes a new command every cycle. Results issued back to back come out back to back, in order.

Top module: `srl_search_latency`

## Requirements
- R1: With table-size code 2'b00, a command presented in cycle c drives the memory-side outputs in cycle c+4.
- R2: With table-size code 2'b01, the memory-side outputs follow the command by 5 cycles.
- R3: With table-size code 2'b10, the memory-side outputs follow the command by 6 cycles. Code 2'b11 behaves the same as 2'b10.
- R4: mem_addr, mem_oe, mem_ce_n, mem_ale_n and mem_we_n for one command all change in the same cycle.
- R5: stat_valid and stat_found for a command appear hold_lat cycles (0 to 7) after that command's memory-side cycle. When hold_lat is 0, stat_valid equals the inverse of mem_ale_n.
- R6: For a hit, the driven cycle has mem_oe=1, mem_ale_n=0, mem_ce_n=0 and mem_addr equal to the winning address. The status cycle has stat_valid=1 and stat_found=1.
- R7: For a miss with both dflt_bank and dflt_dev set, the driven cycle has mem_oe=1, mem_ale_n=0, mem_ce_n=1, mem_we_n=1 and mem_addr equal to the presented address. The status cycle has stat_valid=1 and stat_found=0.
- R8: A miss without both default bits set drives nothing. Its output cycle looks idle on every memory and status output.
- R9: In idle cycles and after reset, mem_oe=0, mem_addr=0, all three strobes are high, and stat_valid and stat_found are 0.
- R10: Commands in consecutive cycles give results in consecutive cycles, with none lost or merged.
- R11: mem_we_n goes low only in a hit cycle whose command carried srch_wr=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_size | input | 2 | Table-size code selecting the latency (00=4, 01=5, 10/11=6) |
| hold_lat | input | 3 | Extra delay of the status pair after the address |
| dflt_bank | input | 1 | Device is last in its bank |
| dflt_dev | input | 1 | Device is last in the cascade |
| srch_cmd | input | 1 | Search result present this cycle |
| srch_hit | input | 1 | Search matched |
| srch_wr | input | 1 | Memory access for this result is a write |
| srch_addr | input | 24 | Winning address |
| mem_addr | output | 24 | Memory address, zero when not driving |
| mem_oe | output | 1 | This device drives the memory bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ale_n | output | 1 | Address latch enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| stat_valid | output | 1 | Delayed search-valid status |
| stat_found | output | 1 | Delayed search-found status |

## Verification
A stage of the pipeline that holds a wrong value shows up at the ports in a predictable cycle. A misplaced tap moves every result one or more cycles, so the address bundle is wrong at cycle c+L for the first command issued. A stage that drops or keeps a value corrupts one result in the middle of a back-to-back burst. The bench covers every table-size code, every hold code and both default-driver settings. In each of these configurations it compares both output groups every cycle against the arithmetic expectation, so any such fault is caught at the first cycle it affects.

// File: rtl/srl_pkg.sv
package srl_pkg;

   typedef enum logic [1:0] {
      TBL_SINGLE = 2'b00,
      TBL_SMALL  = 2'b01,
      TBL_LARGE  = 2'b10,
      TBL_RSVD   = 2'b11
   } tbl_size_e;

   // Extra latency steps above the minimum, clamped to the largest step.
   function automatic int unsigned extra_steps(tbl_size_e code, int unsigned span);
      int unsigned s;
      case (code)
         TBL_SINGLE: s = 0;
         TBL_SMALL:  s = 1;
         default:    s = 2;
      endcase
      return (s > span) ? span : s;
   endfunction

endpackage

// File: rtl/srl_admit.sv
module srl_admit #(
   parameter int ADDR_W = 24
) (
   input  logic              cmd,
   input  logic              hit,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              last_bank,
   input  logic              last_dev,
   output logic              drive,
   output logic [ADDR_W+2:0] bundle
);

   logic is_default;

   always_comb begin
      is_default = last_bank & last_dev;
      drive      = cmd & (hit | is_default);
      bundle     = {drive, drive & hit, drive & hit & wr,
                    drive ? addr : {ADDR_W{1'b0}}};
   end

endmodule

// File: rtl/srl_tap_pipe.sv
module srl_tap_pipe #(
   parameter int W     = 8,
   parameter int DEPTH = 6,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     din,
   input  logic [SEL_W-1:0] sel,
   output logic [W-1:0]     dout
);

   initial begin
      assert (DEPTH >= 1) else $error("srl_tap_pipe: DEPTH must be at least 1");
      assert ((1 << SEL_W) > DEPTH) else $error("srl_tap_pipe: SEL_W too narrow");
   end

   logic [W-1:0] q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[0] <= '0;
      else        q[0] <= din;
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= '0;
         else        q[i] <= q[i-1];
      end
   end

   always_comb begin
      int unsigned idx;
      idx = int'(sel);
      if (idx == 0)          dout = din;
      else if (idx > DEPTH)  dout = q[DEPTH-1];
      else                   dout = q[idx-1];
   end

endmodule

// File: rtl/srl_drive_fmt.sv
module srl_drive_fmt #(
   parameter int ADDR_W = 24
) (
   input  logic [ADDR_W+2:0] bundle,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_oe,
   output logic              mem_ce_n,
   output logic              mem_ale_n,
   output logic              mem_we_n
);

   logic drv, hit, wr;

   always_comb begin
      {drv, hit, wr} = bundle[ADDR_W+2:ADDR_W];
      mem_oe    = drv;
      mem_ale_n = ~drv;
      mem_ce_n  = ~(drv & hit);
      mem_we_n  = ~(drv & hit & wr);
      mem_addr  = drv ? bundle[ADDR_W-1:0] : {ADDR_W{1'b0}};
   end

endmodule

// File: rtl/srl_search_latency.sv
module srl_search_latency #(
   parameter int ADDR_W   = 24,
   parameter int LAT_MIN  = 4,
   parameter int LAT_SPAN = 2,
   parameter int HOLD_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        tbl_size,
   input  logic [2:0]        hold_lat,
   input  logic              dflt_bank,
   input  logic              dflt_dev,
   input  logic              srch_cmd,
   input  logic              srch_hit,
   input  logic              srch_wr,
   input  logic [23:0]       srch_addr,
   output logic [23:0]       mem_addr,
   output logic              mem_oe,
   output logic              mem_ce_n,
   output logic              mem_ale_n,
   output logic              mem_we_n,
   output logic              stat_valid,
   output logic              stat_found
);

   import srl_pkg::*;

   localparam int BW     = ADDR_W + 3;
   localparam int DEPTH1 = LAT_MIN + LAT_SPAN;
   localparam int SEL1_W = $clog2(DEPTH1 + 1);
   localparam int DEPTH2 = (HOLD_W > 0) ? (1 << HOLD_W) - 1 : 1;

   initial begin
      assert (ADDR_W == 24) else $error("srl_search_latency: ADDR_W must match 24-bit ports");
      assert (LAT_MIN >= 1) else $error("srl_search_latency: LAT_MIN must be at least 1");
      assert (LAT_SPAN >= 0 && LAT_SPAN <= 2) else $error("srl_search_latency: LAT_SPAN out of range");
      assert (HOLD_W >= 0 && HOLD_W <= 3) else $error("srl_search_latency: HOLD_W out of range");
   end

   logic              adm_drive;
   logic [BW-1:0]     adm_bundle;
   logic [BW-1:0]     mem_bundle;
   logic [SEL1_W-1:0] lat_sel;
   logic [1:0]        stat_bundle;

   srl_admit #(.ADDR_W(ADDR_W)) i_admit (
      .cmd       (srch_cmd),
      .hit       (srch_hit),
      .wr        (srch_wr),
      .addr      (srch_addr),
      .last_bank (dflt_bank),
      .last_dev  (dflt_dev),
      .drive     (adm_drive),
      .bundle    (adm_bundle)
   );

   always_comb begin
      lat_sel = SEL1_W'(LAT_MIN + int'(extra_steps(tbl_size_e'(tbl_size), LAT_SPAN)));
   end

   srl_tap_pipe #(.W(BW), .DEPTH(DEPTH1), .SEL_W(SEL1_W)) i_addr_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (adm_bundle),
      .sel   (lat_sel),
      .dout  (mem_bundle)
   );

   srl_drive_fmt #(.ADDR_W(ADDR_W)) i_fmt (
      .bundle    (mem_bundle),
      .mem_addr  (mem_addr),
      .mem_oe    (mem_oe),
      .mem_ce_n  (mem_ce_n),
      .mem_ale_n (mem_ale_n),
      .mem_we_n  (mem_we_n)
   );

   if (HOLD_W > 0) begin : g_hold
      localparam int SEL2_W = HOLD_W;
      srl_tap_pipe #(.W(2), .DEPTH(DEPTH2), .SEL_W(SEL2_W)) i_stat_pipe (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (mem_bundle[BW-1 -: 2]),
         .sel   (hold_lat[SEL2_W-1:0]),
         .dout  (stat_bundle)
      );
   end else begin : g_nohold
      assign stat_bundle = mem_bundle[BW-1 -: 2];
   end

   assign stat_valid = stat_bundle[1];
   assign stat_found = stat_bundle[0];

   // Latency checks on the address side.
   p_lat_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_size == 2'b00 && $past(tbl_size, 4) == 2'b00 && $past(rst_n, 4) && $past(adm_drive, 4))
      |-> !mem_ale_n);

   p_lat_large_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_size == 2'b10 && $past(tbl_size, 6) == 2'b10 && $past(rst_n, 6) && $past(adm_drive, 6))
      |-> !mem_ale_n);

   p_status_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_lat == 3'd0 && $past(hold_lat) == 3'd0 && $past(rst_n)) |-> (stat_valid == !mem_ale_n));

   p_found_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_found |-> stat_valid);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ale_n |-> (mem_ce_n && mem_we_n && !mem_oe && mem_addr == '0));

   p_write_in_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n);

endmodule

// File: tb/test_srl_search_latency.sv
module test_srl_search_latency;

   localparam int NCMD = 20;
   localparam int NCYC = 40;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  tbl_size;
   logic [2:0]  hold_lat;
   logic        dflt_bank, dflt_dev;
   logic        srch_cmd, srch_hit, srch_wr;
   logic [23:0] srch_addr;
   logic [23:0] mem_addr;
   logic        mem_oe, mem_ce_n, mem_ale_n, mem_we_n;
   logic        stat_valid, stat_found;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   srl_search_latency i_srl_search_latency (
      .clk(clk), .rst_n(rst_n), .tbl_size(tbl_size), .hold_lat(hold_lat),
      .dflt_bank(dflt_bank), .dflt_dev(dflt_dev), .srch_cmd(srch_cmd),
      .srch_hit(srch_hit), .srch_wr(srch_wr), .srch_addr(srch_addr),
      .mem_addr(mem_addr), .mem_oe(mem_oe), .mem_ce_n(mem_ce_n),
      .mem_ale_n(mem_ale_n), .mem_we_n(mem_we_n),
      .stat_valid(stat_valid), .stat_found(stat_found)
   );

   // Stimulus record: {cmd, hit, wr, addr[23:0]}; idle outside 0..NCMD-1.
   function automatic logic [26:0] stim(int pass, int c);
      logic [31:0] a;
      if (c < 0 || c >= NCMD) return '0;
      a = (c * 32'h0001_3579 + pass * 32'h000A_0B0C) ^ 32'h005A_5A5A;
      return {((c + pass) % 5) != 3, ((c * 7 + pass) % 3) != 1,
              ((c + pass) % 4) == 0, a[23:0]};
   endfunction

   task automatic check(string tag, logic [27:0] act, logic [27:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_cfg(int s, int h, int d);
      int pass, lat;
      string tag_lat;
      pass = s * 16 + h * 2 + d;
      lat  = 4 + ((s > 2) ? 2 : s);
      tag_lat = (s == 0) ? "R1" : (s == 1) ? "R2" : "R3";
      rst_n = 1'b0;
      srch_cmd = 1'b0; srch_hit = 1'b0; srch_wr = 1'b0; srch_addr = '0;
      tbl_size = 2'(s); hold_lat = 3'(h);
      dflt_bank = (d == 1); dflt_dev = 1'b1;
      repeat (3) @(negedge clk);
      // R9: reset state seen at the ports.
      check("R9 reset", {mem_oe, mem_ale_n, mem_ce_n, mem_we_n, mem_addr},
            {1'b0, 1'b1, 1'b1, 1'b1, 24'h0});
      check("R9 reset status", {26'h0, stat_valid, stat_found}, 28'h0);
      rst_n = 1'b1;
      for (int n = 0; n < NCYC; n++) begin
         logic [26:0] r1, r2;
         logic drv1, drv2;
         r1 = stim(pass, n - lat);
         r2 = stim(pass, n - lat - h);
         drv1 = r1[26] & (r1[25] | (d == 1));
         drv2 = r2[26] & (r2[25] | (d == 1));
         // R4 R6 R7 R8 R10 R11 and the size latency tag.
         check({tag_lat, " R4 R6 R7 R8 R10 R11 address side"},
               {mem_oe, mem_ale_n, mem_ce_n, mem_we_n, mem_addr},
               {drv1, ~drv1, ~(drv1 & r1[25]), ~(drv1 & r1[25] & r1[24]),
                drv1 ? r1[23:0] : 24'h0});
         // R5 status shift, R6/R7 found, R8 silence.
         check("R5 R6 R7 R8 status side", {26'h0, stat_valid, stat_found},
               {26'h0, drv2, drv2 & r2[25]});
         {srch_cmd, srch_hit, srch_wr, srch_addr} = stim(pass, n);
         @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      tbl_size = 2'b00; hold_lat = 3'd0;
      dflt_bank = 1'b0; dflt_dev = 1'b0;
      srch_cmd = 1'b0; srch_hit = 1'b0; srch_wr = 1'b0; srch_addr = '0;
      for (int s = 0; s < 4; s++)
         for (int h = 0; h < 8; h++)
            for (int d = 0; d < 2; d++)
               run_cfg(s, h, d);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule